// File: doc/BRIEF.md
# Key-Unlocked Watchdog Timer

This block is a watchdog timer for a slow watchdog clock domain. The slow clock reaches it as a single-cycle enable, `wdt_tick`. The core clock runs the register logic. Software sees one 8-bit control register, which holds the enable, the trip action, the timeout code and a read-only interrupt flag.

Configuration is write-protected. Before software can change enable, trip action or timeout, it must write a 16-bit key to a separate key register. In a full chip that register is shared with a checksum unit. A correct key arms exactly one following control write. Feeding the watchdog never needs the key.

When the count reaches the selected timeout, the block does one of two things. In reset mode it emits a one-cycle reset request. In interrupt mode it sets a sticky flag that drives `irq`. In both modes the count starts again.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, `bus_rdata` reads 0x00 and both `irq` and `rst_req` are low.
- R2: A key-register write (`bus_sel`=1) of `KEY` (default 0x6EA5) on `bus_wdata[15:0]` arms the next control write. A key-register write of any other value disarms it. Any control write (`bus_sel`=0) disarms it.
- R3: The control register fields are mode (bit 5), enable (bit 4) and timeout code (bits 3:0).
  - A control write while not armed leaves all three fields unchanged.
  - An armed control write loads all three fields from the written data.
- R4: A control write with bit 6 set is a feed, whether the block is armed or not. A feed clears the count and the interrupt flag. Bit 6 always reads as 0.
- R5: The timeout is `BASE_TICKS << min(code, 7)` cycles with `wdt_tick` high, counted from the last restart. Cycles with `wdt_tick` low do not count.
- R6: In reset mode (bit 5 = 0), a timeout raises `rst_req` for exactly one cycle, in the cycle after the edge that sampled the final tick. The count then restarts.
- R7: In interrupt mode (bit 5 = 1), a timeout sets the flag (bit 7) and `irq`, restarts the count, and leaves `rst_req` low.
- R8: While enable is 0, the count is held at zero and no timeout occurs.
- R9: Bit 7 is read-only: no write sets or clears it directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 1 | Write target: 0 control register, 1 key register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 8 | Control register readback |
| wdt_tick | input | 1 | Watchdog clock enable, one core cycle per slow tick |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | Interrupt flag output |

## Verification
Directed sequences separate the protection cases from one another:
- a locked write;
- a correctly keyed write;
- a second write after the single use;
- a key overwritten by a wrong value.

Timeouts are then measured at the exact tick count for several codes, including one above 7, and in both trip modes. The tick is gated on and off so that counting is shown to follow `wdt_tick` and not the core clock. Random stimulus mixes feeds, correct and incorrect keys, control writes and irregular ticks, and runs against a cycle model. This shows whether feeds, disables and mode changes interleave correctly with trips.

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter int          BASE_TICKS = 32,
  parameter int          CODE_MAX   = 7,
  parameter logic [15:0] KEY        = 16'h6EA5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic        bus_sel,
  input  logic [15:0] bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        wdt_tick,
  output logic        rst_req,
  output logic        irq
);
  localparam int CW = $clog2(BASE_TICKS << CODE_MAX) + 1;

  logic          armed_q, mode_q, en_q, flag_q, rst_q;
  logic [3:0]    code_q;
  logic [CW-1:0] cnt_q;
  logic [3:0]    code_sat;
  logic [CW-1:0] limit;
  logic [CW:0]   cnt_inc;
  logic          ctl_wr, key_wr, feed, trip;

  assign ctl_wr   = bus_we && !bus_sel;
  assign key_wr   = bus_we &&  bus_sel;
  assign feed     = ctl_wr && bus_wdata[6];
  assign code_sat = (code_q > 4'(CODE_MAX)) ? 4'(CODE_MAX) : code_q;
  assign limit    = CW'(BASE_TICKS) << code_sat;
  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  assign trip     = en_q && !feed && wdt_tick && (cnt_inc >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      mode_q  <= 1'b0;
      en_q    <= 1'b0;
      code_q  <= '0;
    end else begin
      if (key_wr)      armed_q <= (bus_wdata == KEY);
      else if (ctl_wr) armed_q <= 1'b0;
      if (ctl_wr && armed_q) begin
        mode_q <= bus_wdata[5];
        en_q   <= bus_wdata[4];
        code_q <= bus_wdata[3:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_q <= trip && !mode_q;
      if (!en_q || feed || trip) cnt_q <= '0;
      else if (wdt_tick)         cnt_q <= cnt_inc[CW-1:0];
      if (feed)                  flag_q <= 1'b0;
      else if (trip && mode_q)   flag_q <= 1'b1;
    end
  end

  assign bus_rdata = {flag_q, 1'b0, mode_q, en_q, code_q};
  assign rst_req   = rst_q;
  assign irq       = flag_q;

  p_one_shot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !armed_q);
  p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !armed_q) |=> ($stable(mode_q) && $stable(en_q) && $stable(code_q)));
  p_feed_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    feed |=> (!irq && cnt_q == '0));
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < (CW'(BASE_TICKS) << CODE_MAX));
  p_rst_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  p_irq_no_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |=> !rst_req);
  p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (!rst_req && !$rose(irq) && cnt_q == '0));
endmodule

// File: tb/wdt_keyed_tb.sv
module wdt_keyed_tb_top;
  localparam int          BASE = 2;
  localparam logic [15:0] KEY  = 16'h6EA5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 1'b0, bus_sel = 1'b0, wdt_tick = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic rst_req, irq;
  int n_cmp = 0, n_bad = 0;
  logic done = 1'b0;

  logic m_arm, m_mode, m_en, m_flag, m_rst;
  logic [3:0] m_code;
  int m_cnt;

  always #2 clk = ~clk;

  wdt_keyed #(.BASE_TICKS(BASE), .KEY(KEY)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_tick(wdt_tick),
    .rst_req(rst_req), .irq(irq));

  function automatic int limit_of(input logic [3:0] c);
    return BASE << ((c > 4'd7) ? 7 : int'(c));
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_arm = 0; m_mode = 0; m_en = 0; m_flag = 0; m_rst = 0; m_code = 0; m_cnt = 0;
  endtask

  task automatic model_step(input logic we, input logic sel, input logic [15:0] d, input logic tk);
    logic cw, fd, tr;
    cw = we && !sel;
    fd = cw && d[6];
    tr = m_en && !fd && tk && (m_cnt + 1 >= limit_of(m_code));
    m_rst = tr && !m_mode;
    if (fd) m_flag = 0; else if (tr && m_mode) m_flag = 1;
    if (!m_en || fd || tr) m_cnt = 0; else if (tk) m_cnt++;
    if (cw && m_arm) begin m_mode = d[5]; m_en = d[4]; m_code = d[3:0]; end
    if (we && sel) m_arm = (d == KEY); else if (cw) m_arm = 0;
  endtask

  task automatic step(input logic we, input logic sel, input logic [15:0] d, input logic tk);
    bus_we = we; bus_sel = sel; bus_wdata = d; wdt_tick = tk;
    @(posedge clk); #1;
    model_step(we, sel, d, tk);
    bus_we = 0; wdt_tick = 0;
  endtask

  task automatic cmp_model();
    chk("R3/R4/R9 rdata", {8'h0, bus_rdata}, {8'h0, m_flag, 1'b0, m_mode, m_en, m_code});
    chk("R6 rst_req", {15'h0, rst_req}, {15'h0, m_rst});
    chk("R7 irq", {15'h0, irq}, {15'h0, m_flag});
  endtask

  task automatic cfg(input logic [7:0] v);
    step(1, 1, KEY, 0);
    step(1, 0, {8'h0, v}, 0);
  endtask

  task automatic run_to_trip(input logic [3:0] code, input logic mode, input string tag);
    int lim;
    lim = limit_of(code);
    cfg({2'b01, mode, 1'b1, code});
    for (int i = 1; i <= lim; i++) begin
      step(0, 0, 0, 1);
      if (i < lim) chk({tag, " early"}, {14'h0, rst_req, irq}, 16'h0);
      else chk({tag, " trip"}, {14'h0, rst_req, irq}, mode ? 16'h1 : 16'h2);
      if (i == lim / 2) begin
        step(0, 0, 0, 0);
        chk({tag, " R5 idle tick"}, {14'h0, rst_req, irq}, 16'h0);
      end
    end
    step(0, 0, 0, 0);
    chk({tag, " after"}, {15'h0, rst_req}, 16'h0);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    chk("R1 rdata", {8'h0, bus_rdata}, 16'h0);
    chk("R1 outs", {14'h0, rst_req, irq}, 16'h0);

    step(1, 0, 16'h003F, 0);
    chk("R3 locked write", {8'h0, bus_rdata}, 16'h0);
    cfg(8'h10);
    chk("R2 keyed write", {8'h0, bus_rdata}, 16'h10);
    step(1, 0, 16'h0011, 0);
    chk("R2 single use", {8'h0, bus_rdata}, 16'h10);
    step(1, 1, KEY, 0); step(1, 1, 16'h6EA4, 0); step(1, 0, 16'h0013, 0);
    chk("R2 wrong key disarms", {8'h0, bus_rdata}, 16'h10);
    step(1, 0, 16'h0080, 0);
    chk("R9 bit7 read-only", {8'h0, bus_rdata}, 16'h10);

    run_to_trip(4'd0, 1'b0, "R6 code0");
    run_to_trip(4'd2, 1'b0, "R5 code2");
    run_to_trip(4'd1, 1'b1, "R7 code1");
    chk("R7 flag bit7", {8'h0, bus_rdata}, 16'hB1);
    step(1, 0, 16'h0040, 0);
    chk("R4 feed clears flag", {14'h0, rst_req, irq}, 16'h0);
    run_to_trip(4'd9, 1'b0, "R5 code9 saturates");

    cfg(8'h01);
    for (int i = 0; i < 600; i++) begin
      step(0, 0, 0, 1);
      if (rst_req || irq) begin chk("R8 disabled trip", {14'h0, rst_req, irq}, 16'h0); break; end
    end
    chk("R8 disabled quiet", {14'h0, rst_req, irq}, 16'h0);

    cfg(8'h10);
    for (int i = 0; i < 40; i++) begin
      step(i % 2 == 0, 0, 16'h0040, 1);
      if (rst_req) break;
    end
    chk("R4 feed holds off trip", {15'h0, rst_req}, 16'h0);

    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic we, sel, tk;
      logic [15:0] d;
      int r;
      r = $urandom_range(0, 99);
      we = r < 12;
      sel = $urandom_range(0, 1);
      tk = $urandom_range(0, 3) != 0;
      d = {8'h0, $urandom_range(0, 255)};
      if (!sel && $urandom_range(0, 3) != 0) d[6] = 1'b0;
      if (!sel) d[3] = 1'b0;
      if (sel && $urandom_range(0, 1) == 1) d = KEY;
      step(we, sel, d, tk);
      cmp_model();
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule